// File: doc/BRIEF.md
# Interlocked Bus Master Sequencer

This block runs the master side of a fully interlocked two-wire bus handshake from a single system clock. The host loads an 18-bit byte address, then requests word cycles one at a time, each as a write (data sent to a slave) or a read (data fetched from a slave). For each cycle the sequencer holds the bus busy line and drives address, a control code and, on writes, the data word. It then raises the master strobe and waits for the slave's acknowledge.

Every bus delay is a whole number of clocks derived from parameters: a setup delay before the strobe, a deskew delay after the acknowledge, and a no-response timeout while the strobe is high. The acknowledge is synchronized with two flip-flops before any use. After each completed word the address register steps by one word. A cycle that times out releases the bus and latches an error. The host must clear that error before another cycle can start.

Top module: `bus_master_seq`

## Requirements
- R1: After reset, msyn_o, bbsy_o, bus_data_oe_o, done_o and err_o are 0, and bus_addr_o, bus_ctrl_o and bus_data_o are all zero.
- R2: Once a cycle starts, bbsy_o, bus_addr_o and bus_ctrl_o are driven for exactly SETUP_CYC clocks (ceil(SETUP_NS / clock period), 38 at the defaults) with msyn_o low before msyn_o rises. The control code is 2'b10 for a write and 2'b00 for a read. bus_data_oe_o is 1 only for writes, and the write word appears on bus_data_o at the same time.
- R3: On a write, msyn_o falls within 3 clocks of ssyn_i rising. Address, control and data then stay unchanged, with bbsy_o high, for exactly DESKEW_CYC clocks (ceil(DESKEW_NS / period), 19 at the defaults). After that all bus outputs return to zero.
- R4: On a read, bus_data_oe_o stays 0. After ssyn_i rises, msyn_o stays high for at least DESKEW_CYC and at most DESKEW_CYC+3 clocks. At the edge where msyn_o falls, bus_data_i is captured into rdata_o and the bus is released.
- R5: done_o is high for exactly one clock after each normal cycle: the first clock in which bbsy_o is low again.
- R6: Bit 0 of a loaded address is forced to 0. After each normal cycle the address grows by 2, modulo 2^18 (0x3FFFE is followed by 0x00000).
- R7: addr_load_i takes effect only while no cycle is in progress. A load during a cycle has no effect.
- R8: msyn_o does not rise for a new cycle while ssyn_i from the previous cycle is still high. Setup begins only once ssyn_i has been released.
- R9: If ssyn_i does not arrive, msyn_o stays high for exactly TIMEOUT_CYC clocks (2500 at the defaults). Then all bus outputs drop to zero in the same clock and err_o rises. done_o stays low and the address does not advance.
- R10: While err_o is set, start_i is ignored. err_clr_i clears err_o, after which start_i works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one word cycle (taken while idle and error-free) |
| write_i | input | 1 | Cycle direction sampled with start_i: 1 write, 0 read |
| wdata_i | input | 16 | Write word sampled with start_i |
| addr_load_i | input | 1 | Load the address register while idle |
| addr_value_i | input | 18 | Address value to load |
| err_clr_i | input | 1 | Clear the timeout error flag |
| rdata_o | output | 16 | Last word read from the bus |
| done_o | output | 1 | One-clock pulse per completed cycle |
| err_o | output | 1 | Sticky timeout error |
| bus_addr_o | output | 18 | Bus address, zero when released |
| bus_ctrl_o | output | 2 | Bus control code, zero when released |
| bus_data_o | output | 16 | Bus write data, zero when not driven |
| bus_data_oe_o | output | 1 | Bus data output enable |
| bus_data_i | input | 16 | Bus data from slave |
| msyn_o | output | 1 | Master strobe |
| bbsy_o | output | 1 | Bus busy |
| ssyn_i | input | 1 | Slave acknowledge, asynchronous |

## Verification
A timer loaded with the wrong value shows up in the same cycle as a wrong count. The bench checks the setup, deskew and timeout windows to the exact clock count, so an off-by-one is caught within that cycle. A missed or extra address step appears as a wrong bus address in the setup window of the next cycle, tens of clocks later. A corrupted state leaves msyn_o stuck, a done pulse missing or doubled, or err_o set without a timeout, and these are seen within a handful of clocks after the acknowledge.

// File: rtl/bus_master_pkg.sv
`timescale 1ns/1ps
package bus_master_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REL,
    ST_SETUP,
    ST_SYNC,
    ST_DESKEW,
    ST_HOLD
  } seq_state_e;

  localparam logic [1:0] CTRL_READ  = 2'b00;
  localparam logic [1:0] CTRL_WRITE = 2'b10;

  function automatic int ns_to_cycles(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ssyn_sync.sv
`timescale 1ns/1ps
module ssyn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/delay_timer.sv
`timescale 1ns/1ps
module delay_timer #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (val_i != '0)) |=> !zero_o);
endmodule

// File: rtl/bus_addr_reg.sv
`timescale 1ns/1ps
module bus_addr_reg #(
  parameter int ADDR_W = 18,
  parameter int STEP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] val_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= {val_i[ADDR_W-1:1], 1'b0};
    else if (adv_i)  addr_o <= addr_o + STEP_V;
  end

  // R6
  even_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o[0] == 1'b0));
endmodule

// File: rtl/bus_master_seq.sv
`timescale 1ns/1ps
module bus_master_seq
  import bus_master_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int SETUP_NS      = 150,
  parameter int DESKEW_NS     = 75,
  parameter int TIMEOUT_NS    = 10000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_value_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_ctrl_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              msyn_o,
  output logic              bbsy_o,
  input  logic              ssyn_i
);
  localparam int SETUP_CYC   = ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
  localparam int DESKEW_CYC  = ns_to_cycles(DESKEW_NS, CLK_PERIOD_PS);
  localparam int TIMEOUT_CYC = ns_to_cycles(TIMEOUT_NS, CLK_PERIOD_PS);
  localparam int MAX_A       = (SETUP_CYC > DESKEW_CYC) ? SETUP_CYC : DESKEW_CYC;
  localparam int MAX_CYC     = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int TW          = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] SETUP_LD   = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] DESKEW_LD  = TW'(DESKEW_CYC - 1);
  localparam logic [TW-1:0] TIMEOUT_LD = TW'(TIMEOUT_CYC - 1);

  seq_state_e        state_q, state_d;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q, err_q;
  logic              ssyn_s;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              adv, done_set, err_set, capture, accept;
  logic [ADDR_W-1:0] addr_q;
  logic              driving;

  ssyn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ssyn_i),
    .sync_o  (ssyn_s)
  );

  delay_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  bus_addr_reg #(.ADDR_W(ADDR_W), .STEP(2)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_load_i && (state_q == ST_IDLE)),
    .val_i  (addr_value_i),
    .adv_i  (adv),
    .addr_o (addr_q)
  );

  assign accept = (state_q == ST_IDLE) && start_i && !err_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    adv      = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_WAIT_REL;
      ST_WAIT_REL:
        if (!ssyn_s) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      ST_SETUP:
        if (tmr_zero) begin
          state_d  = ST_SYNC;
          tmr_load = 1'b1;
          tmr_val  = TIMEOUT_LD;
        end
      ST_SYNC:
        if (ssyn_s) begin
          state_d  = wr_q ? ST_HOLD : ST_DESKEW;
          tmr_load = 1'b1;
          tmr_val  = DESKEW_LD;
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          err_set = 1'b1;
        end
      ST_DESKEW:
        if (tmr_zero) begin
          state_d  = ST_IDLE;
          capture  = 1'b1;
          adv      = 1'b1;
          done_set = 1'b1;
        end
      ST_HOLD:
        if (tmr_zero) begin
          state_d  = ST_IDLE;
          adv      = 1'b1;
          done_set = 1'b1;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_set;
      if (accept) begin
        wr_q    <= write_i;
        wdata_q <= wdata_i;
      end
      if (capture)        rdata_q <= bus_data_i;
      if (err_set)        err_q   <= 1'b1;
      else if (err_clr_i) err_q   <= 1'b0;
    end
  end

  assign driving       = (state_q == ST_SETUP) || (state_q == ST_SYNC) ||
                         (state_q == ST_DESKEW) || (state_q == ST_HOLD);
  assign msyn_o        = (state_q == ST_SYNC) || (state_q == ST_DESKEW);
  assign bbsy_o        = driving;
  assign bus_addr_o    = driving ? addr_q : '0;
  assign bus_ctrl_o    = driving ? (wr_q ? CTRL_WRITE : CTRL_READ) : 2'b00;
  assign bus_data_oe_o = driving && wr_q;
  assign bus_data_o    = bus_data_oe_o ? wdata_q : '0;
  assign rdata_o       = rdata_q;
  assign done_o        = done_q;
  assign err_o         = err_q;

  // R8
  no_strobe_on_stale_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msyn_o) |-> !ssyn_s);

  // R2
  bus_stable_under_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msyn_o && $past(msyn_o)) |-> ($stable(bus_addr_o) && $stable(bus_ctrl_o) && $stable(bus_data_o)));

  // R9
  timeout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (!msyn_o && !bbsy_o && !done_o));

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  step_per_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((addr_q - $past(addr_q)) == ADDR_W'(2)));
endmodule

// File: tb/bus_master_seq_test.sv
`timescale 1ns/1ps
module bus_master_seq_test;
  localparam int PERIOD_PS = 4000;
  localparam int S_CYC = (150 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int D_CYC = (75 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int T_CYC = (10000 * 1000 + PERIOD_PS - 1) / PERIOD_PS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, write_i = 1'b0, addr_load_i = 1'b0, err_clr_i = 1'b0;
  logic [15:0] wdata_i = '0, bus_data_i = '0;
  logic [17:0] addr_value_i = '0;
  logic        ssyn_i = 1'b0;
  logic [15:0] rdata_o, bus_data_o;
  logic        done_o, err_o, bus_data_oe_o, msyn_o, bbsy_o;
  logic [17:0] bus_addr_o;
  logic [1:0]  bus_ctrl_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  bus_master_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .wdata_i(wdata_i), .addr_load_i(addr_load_i), .addr_value_i(addr_value_i),
    .err_clr_i(err_clr_i), .rdata_o(rdata_o), .done_o(done_o), .err_o(err_o),
    .bus_addr_o(bus_addr_o), .bus_ctrl_o(bus_ctrl_o), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_data_oe_o), .bus_data_i(bus_data_i), .msyn_o(msyn_o),
    .bbsy_o(bbsy_o), .ssyn_i(ssyn_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic load_addr(input logic [17:0] v);
    step();
    addr_load_i = 1'b1; addr_value_i = v;
    step();
    addr_load_i = 1'b0;
  endtask

  task automatic pulse_start(input bit wr, input logic [15:0] d);
    step();
    start_i = 1'b1; write_i = wr; wdata_i = d;
    step();
    start_i = 1'b0;
  endtask

  // Counts setup clocks up to msyn rise; returns with msyn high (or guard hit)
  task automatic wait_strobe(input bit wr, input logic [17:0] ea, input logic [15:0] d);
    int n = 0;
    int g = 0;
    while (!msyn_o && g < 5000) begin
      if (bbsy_o) n++;
      g++;
      step();
    end
    check(n == S_CYC, "R2", "setup clocks", n, S_CYC);
    check(bus_addr_o == ea, "R6", "bus address", bus_addr_o, ea);
    check(bus_ctrl_o == (wr ? 2'b10 : 2'b00), "R2", "control code", bus_ctrl_o, wr ? 2'b10 : 2'b00);
    check(bus_data_oe_o == wr, "R2", "data enable", bus_data_oe_o, wr);
    if (wr) check(bus_data_o == d, "R2", "write data", bus_data_o, d);
  endtask

  task automatic run_cycle(input bit wr, input logic [17:0] ea, input logic [15:0] d,
                           input int dly, input bit load_mid, input bit keep_ssyn);
    int n = 0;
    int h = 0;
    wait_strobe(wr, ea, d);
    for (int i = 0; i < dly; i++) begin
      if (load_mid && i == 0) begin addr_load_i = 1'b1; addr_value_i = 18'h2AAAA; end
      if (load_mid && i == 1) addr_load_i = 1'b0;
      step();
    end
    addr_load_i = 1'b0;
    ssyn_i = 1'b1;
    if (!wr) bus_data_i = d;
    step();
    while (msyn_o && n < 5000) begin n++; step(); end
    if (wr) begin
      check(n >= 1 && n <= 3, "R3", "strobe drop delay", n, 2);
      while (bbsy_o && h < 5000) begin
        if (bus_addr_o != ea || bus_data_o != d)
          check(1'b0, "R3", "hold stability", bus_addr_o, ea);
        h++;
        step();
      end
      check(h == D_CYC, "R3", "hold clocks", h, D_CYC);
      check(bus_addr_o == 0 && bus_data_oe_o == 0 && bus_ctrl_o == 0, "R3", "bus released",
            bus_addr_o, 0);
    end else begin
      check(n >= D_CYC && n <= D_CYC + 3, "R4", "read deskew clocks", n, D_CYC + 2);
      check(!bbsy_o, "R4", "bus released at strobe", bbsy_o, 0);
      check(rdata_o == d, "R4", "read data", rdata_o, d);
    end
    check(done_o == 1'b1, "R5", "done pulse", done_o, 1);
    step();
    check(done_o == 1'b0, "R5", "done width", done_o, 0);
    if (!keep_ssyn) begin
      ssyn_i = 1'b0;
      bus_data_i = '0;
    end
  endtask

  task automatic t_reset();
    check(!msyn_o && !bbsy_o && !bus_data_oe_o && !done_o && !err_o, "R1", "control outputs",
          {msyn_o, bbsy_o, bus_data_oe_o, done_o, err_o}, 0);
    check(bus_addr_o == 0 && bus_ctrl_o == 0 && bus_data_o == 0, "R1", "bus outputs",
          bus_addr_o, 0);
  endtask

  task automatic t_write_read();
    load_addr(18'h01000);
    pulse_start(1'b1, 16'hA5A5);
    run_cycle(1'b1, 18'h01000, 16'hA5A5, 5, 1'b0, 1'b0);
    pulse_start(1'b0, 16'h0);
    run_cycle(1'b0, 18'h01002, 16'h1234, 3, 1'b0, 1'b0);
  endtask

  task automatic t_load_ignored();
    // R7: load during a cycle has no effect
    pulse_start(1'b1, 16'h5A5A);
    run_cycle(1'b1, 18'h01004, 16'h5A5A, 4, 1'b1, 1'b0);
    pulse_start(1'b0, 16'h0);
    run_cycle(1'b0, 18'h01006, 16'hBEEF, 2, 1'b0, 1'b0);
    check(1'b1, "R7", "load ignored (address checked above)", 0, 0);
  endtask

  task automatic t_wrap();
    load_addr(18'h3FFFF);
    pulse_start(1'b1, 16'h0F0F);
    run_cycle(1'b1, 18'h3FFFE, 16'h0F0F, 2, 1'b0, 1'b0);
    pulse_start(1'b0, 16'h0);
    run_cycle(1'b0, 18'h00000, 16'hC3C3, 6, 1'b0, 1'b0);
  endtask

  task automatic t_stale_ack();
    bit quiet = 1'b1;
    load_addr(18'h00200);
    pulse_start(1'b1, 16'h1111);
    run_cycle(1'b1, 18'h00200, 16'h1111, 2, 1'b0, 1'b1);
    pulse_start(1'b0, 16'h0);
    for (int i = 0; i < 80; i++) begin
      if (msyn_o || bbsy_o) quiet = 1'b0;
      step();
    end
    check(quiet, "R8", "no strobe while ack held", quiet, 1);
    ssyn_i = 1'b0;
    run_cycle(1'b0, 18'h00202, 16'h7777, 3, 1'b0, 1'b0);
  endtask

  task automatic t_timeout();
    int n = 0;
    bit quiet = 1'b1;
    load_addr(18'h00100);
    pulse_start(1'b1, 16'h4444);
    wait_strobe(1'b1, 18'h00100, 16'h4444);
    while (msyn_o && n < 10000) begin n++; step(); end
    check(n == T_CYC, "R9", "timeout clocks", n, T_CYC);
    check(!bbsy_o && bus_addr_o == 0 && !bus_data_oe_o, "R9", "bus released", bbsy_o, 0);
    check(err_o, "R9", "error flag", err_o, 1);
    check(!done_o, "R9", "no done on timeout", done_o, 0);
    pulse_start(1'b0, 16'h0);
    for (int i = 0; i < 60; i++) begin
      if (msyn_o || bbsy_o) quiet = 1'b0;
      step();
    end
    check(quiet, "R10", "start blocked by error", quiet, 1);
    err_clr_i = 1'b1;
    step();
    err_clr_i = 1'b0;
    check(!err_o, "R10", "error cleared", err_o, 0);
    pulse_start(1'b0, 16'h0);
    run_cycle(1'b0, 18'h00100, 16'h9999, 4, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_write_read();
    t_load_ignored();
    t_wrap();
    t_stale_ack();
    t_timeout();
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule